// File: doc/BRIEF.md
# Aging-Register Replacement Picker

This block keeps an approximate recency history for a small set of page frames and always names the frame that is the best candidate for eviction. Each frame owns a short history register. Whenever the memory system reports that a frame was referenced, every register moves one position toward its low end, and the referenced frame gets a one in its top position. A frame that has not been touched for a long time ends up with a small value. A frame that was touched recently has a large value.

The eviction candidate is the frame with the smallest history value. When several frames share that value, the lowest frame index wins. The candidate comes from the registers through combinational logic only, so a replacement engine can read it in any cycle. When a new page is placed into a frame, the load strobe clears that frame's history, which makes it the oldest. The block does not hold page data and does not translate addresses.

Top module: `frame_age_lru`

## Requirements
- R1: After reset every history register is zero, so `victimFrame` is 0 and `victimAge` is 0.
- R2: When `refValid` is high at a clock edge, the frame whose binary index equals `refFrame` gets bit NUM_AGE_BITS-1 (the most significant bit) of its register set to 1.
- R3: In a cycle with `refValid` high, every register shifts right by one bit. Its old least significant bit is dropped. Every frame that is not referenced gets a 0 in the most significant bit.
- R4: When `loadValid` is high at a clock edge, the register of the frame indexed by `loadFrame` becomes zero. The clear wins over a mark to the same frame in the same cycle. The other frames still follow R2 and R3.
- R5: In a cycle where both `refValid` and `loadValid` are low, no register changes.
- R6: `victimFrame` names a frame whose register value is the minimum over all frames. `victimAge` equals that value. Both follow the registers combinationally.
- R7: When several frames hold the minimum value, `victimFrame` is the lowest of their indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| refValid | input | 1 | A frame reference occurs this cycle |
| refFrame | input | 3 | Binary index of the referenced frame |
| loadValid | input | 1 | A new page is placed this cycle |
| loadFrame | input | 3 | Binary index of the frame being filled |
| victimFrame | output | 3 | Index of the frame with the smallest history (ties go to the lowest index) |
| victimAge | output | 8 | History value of the named frame |

## Verification
Register updates land on the rising edge where the strobe is sampled. Because the candidate is combinational from the registers, both outputs are due one edge after the stimulus is applied. The bench drives inputs on the falling edge, applies the same update to its own arithmetic model at the following rising edge, and compares 1 ns later, long before the next drive. Idle, load-only and mixed cycles are checked in the same way. A wrong hold, clear or shift therefore shows up at the very next comparison.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

  // Strobes from the control decode to the history datapath.
  typedef struct packed {
    logic shiftEn;   // a reference is being applied this cycle
    logic markEn;    // the referenced frame gets its top bit set
    logic clearEn;   // a frame is being refilled this cycle
  } ageStrobes_t;

endpackage

// File: rtl/lru_age_ctrl.sv
module lru_age_ctrl
  import lru_age_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refValid,
  input  logic [IDX_W-1:0]      refFrame,
  input  logic                  loadValid,
  input  logic [IDX_W-1:0]      loadFrame,
  output ageStrobes_t           strobes,
  output logic [NUM_FRAMES-1:0] markMask,
  output logic [NUM_FRAMES-1:0] clearMask
);

  always_comb begin
    strobes.shiftEn = refValid;
    strobes.markEn  = refValid;
    strobes.clearEn = loadValid;
  end

  // One-hot decode of both frame indices.
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_decode
    always_comb begin
      markMask[g]  = refValid  && (refFrame  == IDX_W'(g));
      clearMask[g] = loadValid && (loadFrame == IDX_W'(g));
    end
  end

  AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    refValid |-> $countones(markMask) == 1) // R2
    else $error("mark mask is not one-hot");

  AST_CLEAR_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clearMask)) // R4
    else $error("clear mask has several bits");

endmodule

// File: rtl/lru_age_regs.sv
module lru_age_regs
  import lru_age_pkg::*;
#(
  parameter int NUM_FRAMES   = 8,
  parameter int NUM_AGE_BITS = 8
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  ageStrobes_t                              strobes,
  input  logic [NUM_FRAMES-1:0]                    markMask,
  input  logic [NUM_FRAMES-1:0]                    clearMask,
  output logic [NUM_FRAMES-1:0][NUM_AGE_BITS-1:0]  ageQ
);

  logic [NUM_FRAMES-1:0][NUM_AGE_BITS-1:0] ageD;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    always_comb begin
      ageD[g] = ageQ[g];
      if (strobes.shiftEn)
        ageD[g] = {strobes.markEn & markMask[g], ageQ[g][NUM_AGE_BITS-1:1]};
      if (strobes.clearEn && clearMask[g])
        ageD[g] = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ageQ[g] <= '0;
      else       ageQ[g] <= ageD[g];
    end

    AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!rstN)
      strobes.shiftEn && !(strobes.clearEn && clearMask[g])
      |=> ageQ[g][NUM_AGE_BITS-2:0] == $past(ageQ[g][NUM_AGE_BITS-1:1])) // R3
      else $error("frame %0d did not shift", g);

    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rstN)
      strobes.shiftEn && !(strobes.clearEn && clearMask[g])
      |=> ageQ[g][NUM_AGE_BITS-1] == $past(markMask[g])) // R2
      else $error("frame %0d top bit wrong", g);

    AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clearEn && clearMask[g] |=> ageQ[g] == '0) // R4
      else $error("frame %0d not cleared", g);
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftEn && !strobes.clearEn |=> $stable(ageQ)) // R5
    else $error("history changed in idle cycle");

endmodule

// File: rtl/lru_age_pick.sv
module lru_age_pick #(
  parameter int NUM_FRAMES   = 8,
  parameter int NUM_AGE_BITS = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [NUM_FRAMES-1:0][NUM_AGE_BITS-1:0] ageIn,
  output logic [IDX_W-1:0]                        victimFrame,
  output logic [NUM_AGE_BITS-1:0]                 victimAge
);

  // Linear scan; strict less-than keeps the lowest index on ties.
  always_comb begin
    victimFrame = '0;
    victimAge   = ageIn[0];
    for (int i = 1; i < NUM_FRAMES; i++) begin
      if (ageIn[i] < victimAge) begin
        victimAge   = ageIn[i];
        victimFrame = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_chk
    AST_VICTIM_MIN: assert property (@(posedge clk) disable iff (!rstN)
      ageIn[victimFrame] <= ageIn[g]) // R6
      else $error("victim larger than frame %0d", g);

    AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
      ageIn[g] == ageIn[victimFrame] |-> victimFrame <= IDX_W'(g)) // R7
      else $error("tie not resolved to lowest index");
  end

endmodule

// File: rtl/frame_age_lru.sv
module frame_age_lru
  import lru_age_pkg::*;
#(
  parameter int NUM_FRAMES   = 8,
  parameter int NUM_AGE_BITS = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refValid,
  input  logic [IDX_W-1:0]        refFrame,
  input  logic                    loadValid,
  input  logic [IDX_W-1:0]        loadFrame,
  output logic [IDX_W-1:0]        victimFrame,
  output logic [NUM_AGE_BITS-1:0] victimAge
);

  ageStrobes_t                             strobes;
  logic [NUM_FRAMES-1:0]                   markMask;
  logic [NUM_FRAMES-1:0]                   clearMask;
  logic [NUM_FRAMES-1:0][NUM_AGE_BITS-1:0] ageQ;

  lru_age_ctrl #(.NUM_FRAMES(NUM_FRAMES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .refValid(refValid), .refFrame(refFrame),
    .loadValid(loadValid), .loadFrame(loadFrame),
    .strobes(strobes), .markMask(markMask), .clearMask(clearMask)
  );

  lru_age_regs #(.NUM_FRAMES(NUM_FRAMES), .NUM_AGE_BITS(NUM_AGE_BITS)) i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .markMask(markMask), .clearMask(clearMask), .ageQ(ageQ)
  );

  lru_age_pick #(.NUM_FRAMES(NUM_FRAMES), .NUM_AGE_BITS(NUM_AGE_BITS)) i_pick (
    .clk(clk), .rstN(rstN), .ageIn(ageQ),
    .victimFrame(victimFrame), .victimAge(victimAge)
  );

endmodule

// File: tb/test_frame_age_lru.sv
module test_frame_age_lru;

  localparam int NF = 8;
  localparam int NB = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refValid = 1'b0;
  logic [IW-1:0] refFrame = '0;
  logic          loadValid = 1'b0;
  logic [IW-1:0] loadFrame = '0;
  logic [IW-1:0] victimFrame;
  logic [NB-1:0] victimAge;

  int vecCount = 0;
  int badCount = 0;
  bit finished = 1'b0;
  logic [NB-1:0] model [NF];

  always #2 clk = ~clk;

  frame_age_lru i_frame_age_lru (
    .clk(clk), .rstN(rstN),
    .refValid(refValid), .refFrame(refFrame),
    .loadValid(loadValid), .loadFrame(loadFrame),
    .victimFrame(victimFrame), .victimAge(victimAge)
  );

  task automatic checkOutputs(input string req);
    int bestIdx = 0;
    logic [NB-1:0] bestVal = model[0];
    for (int i = 1; i < NF; i++)
      if (model[i] < bestVal) begin bestVal = model[i]; bestIdx = i; end
    vecCount++;
    if (victimFrame !== IW'(bestIdx)) begin
      badCount++;
      $display("FAIL %s victimFrame actual %0d expected %0d", req, victimFrame, bestIdx);
    end
    vecCount++;
    if (victimAge !== bestVal) begin
      badCount++;
      $display("FAIL %s victimAge actual %0h expected %0h", req, victimAge, bestVal);
    end
  endtask

  // Drive on the falling edge, update the model at the rising edge, compare 1 ns later.
  task automatic step(input bit rv, input int rf, input bit lv, input int lf, input string req);
    @(negedge clk);
    refValid = rv; refFrame = IW'(rf); loadValid = lv; loadFrame = IW'(lf);
    @(posedge clk);
    if (rv) for (int i = 0; i < NF; i++)
      model[i] = {(i == rf) ? 1'b1 : 1'b0, model[i][NB-1:1]};
    if (lv) model[lf] = '0;
    #1;
    refValid = 1'b0; loadValid = 1'b0;
    checkOutputs(req);
  endtask

  initial begin
    for (int i = 0; i < NF; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    checkOutputs("R1");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    checkOutputs("R1");

    // R2, R3: reference every frame in turn, then in reverse.
    for (int f = 0; f < NF; f++) step(1, f, 0, 0, "R2");
    for (int f = NF - 1; f >= 0; f--) step(1, f, 0, 0, "R3");
    // R3: repeated hits on one frame age all the others toward zero.
    for (int k = 0; k < NB + 2; k++) step(1, 5, 0, 0, "R3");
    // R5: idle cycles hold everything.
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, "R5");
    // R4: load-only clears each frame without touching the rest.
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < NF; k++) step(1, k, 0, 0, "R2");
      step(0, 0, 1, f, "R4");
    end
    // R4: reference and load together, same frame and different frame.
    for (int f = 0; f < NF; f++) begin
      step(1, f, 1, f, "R4");
      step(1, f, 1, (f + 3) % NF, "R4");
    end
    // R7: ties. Load every frame (all zero), then mark subsets.
    for (int f = 0; f < NF; f++) step(0, 0, 1, f, "R7");
    for (int f = 0; f < NF; f++) step(1, f, 0, 0, "R7");
    for (int f = 0; f < NF; f++) step(0, 0, 1, NF - 1 - f, "R7");
    // R6: pseudo-random mix.
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), lfsr[7] & lfsr[8] & lfsr[9],
             int'(lfsr[12:10]), "R6");
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      badCount++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

endmodule